// File: doc/BRIEF.md
# Dual-Channel Host Register Bus Decoder

This block sits between a host CPU bus and two serial-channel register sets, called channel A and channel B. The host drives an 8-bit write data bus, a 3-bit register address, an active-low chip select, a channel select line and two active-low strobes, one for reads and one for writes. The block sends each write to the register set that channel select names. It returns read data from the selected channel. When a broadcast bit is set, one write cycle updates the same register in both channels. This lets start-up code program both channels with a single set of writes.

Each channel holds eight 8-bit registers. The register at address 7 is that channel's configuration register. Bit 0 of this register is the broadcast enable, and bits 2:1 select what the channel's multi-function output shows. There are three per-channel status inputs: a general-purpose output level, a baud clock and a receiver-ready flag. Multi-bit per-channel ports use bit 0 for channel A and bit 1 for channel B. All bus inputs are assumed synchronous to `clk`.

Top module: `dual_chan_bus_front`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all sixteen registers. This turns broadcast off and sets both multi-function selects to 00.
- R2: While `cs_n` is high, no register changes and a read returns zero with `rd_oe` low.
- R3: With `cs_n` low and broadcast off, `chan_sel` = 1 addresses channel A and `chan_sel` = 0 addresses channel B, for both reads and writes.
- R4: `addr` picks one of the eight registers of the addressed channel. A write changes only that register.
- R5: A write is committed at the first clock edge where `wr_n` is sampled high after having been sampled low. It uses the `cs_n`, `chan_sel`, `addr` and `wr_data` present at that edge. Holding `wr_n` low commits nothing.
- R6: Broadcast is on when bit 0 of either channel's register 7 is 1. While it is on, a write lands in the same register of both channels whatever `chan_sel` is.
- R7: Reads during broadcast still return the channel named by `chan_sel`.
- R8: When no read is active (`cs_n` or `rd_n` high), `rd_data` is 0 and `rd_oe` is 0. During a read, `rd_oe` is 1 and `rd_data` shows the addressed register combinationally.
- R9: Each channel's `mf_out` bit follows bits 2:1 of its register 7: 00 gives `gp_lvl`, 01 gives `baud_clk`, 10 gives `rx_rdy`, and 11 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | 1 = channel A, 0 = channel B |
| addr | input | 3 | Register index within the channel |
| wr_n | input | 1 | Write strobe, active low, commit on rise |
| rd_n | input | 1 | Read strobe, active low |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when idle |
| rd_oe | output | 1 | High while a read is active |
| gp_lvl | input | 2 | General output level per channel |
| baud_clk | input | 2 | Baud clock per channel |
| rx_rdy | input | 2 | Receiver-ready flag per channel |
| mf_out | output | 2 | Multi-function output per channel |

## Verification
The bench builds the block with its default parameters: 8-bit data and 3 address bits, so each channel has eight registers with the configuration register at index 7. With these widths, the bench can keep a full reference copy of all sixteen registers and compare every one of them after each phase. This covers writes that stray into the wrong register or channel, broadcast copies, and all four multi-function codes in both channels at once.

// File: rtl/dcbf_pkg.sv
package dcbf_pkg;

  typedef enum logic [1:0] {
    MF_GP    = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RXRDY = 2'b10,
    MF_ZERO  = 2'b11
  } mf_sel_t;

  // channel select line to register-set index (0 = A, 1 = B)
  function automatic logic chan_index(input logic sel_line);
    return ~sel_line;
  endfunction

  function automatic logic mf_pick(input mf_sel_t s, input logic gp,
                                   input logic baud, input logic rx);
    logic r;
    case (s)
      MF_GP:    r = gp;
      MF_BAUD:  r = baud;
      MF_RXRDY: r = rx;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bus_decode.sv
module bus_decode #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              chan_sel,
  input  logic              wr_n,
  input  logic              bcast,
  output logic              wr_evt,
  output logic [NUM_CH-1:0] we_vec
);
  import dcbf_pkg::*;

  logic wr_prev;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b1;
    else     wr_prev <= wr_n;
  end

  // strobe rise seen at this edge, with chip select active
  assign wr_evt = ~wr_prev & wr_n & ~cs_n;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_we
    assign we_vec[ch] = wr_evt & (bcast | (chan_index(chan_sel) == 1'(ch)));
  end

  a_r2_no_we_without_cs: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> we_vec == '0);
  a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
    (we_vec != '0) |=> we_vec == '0);
  a_r6_bcast_both: assert property (@(posedge clk) disable iff (rst)
    (bcast && wr_evt) |-> &we_vec);
  a_r3_one_channel: assert property (@(posedge clk) disable iff (rst)
    (!bcast) |-> $onehot0(we_vec));

endmodule

// File: rtl/chan_regfile.sv
module chan_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cfg
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CFG_IDX = DEPTH - 1;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign cfg   = mem[CFG_IDX];

  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
  a_r5_hold_no_we: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));

endmodule

// File: rtl/mf_select.sv
module mf_select (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       gp,
  input  logic       baud,
  input  logic       rx,
  output logic       mf
);
  import dcbf_pkg::*;

  assign mf = mf_pick(mf_sel_t'(sel), gp, baud, rx);

  a_r9_reserved_low: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |-> !mf);

endmodule

// File: rtl/dual_chan_bus_front.sv
module dual_chan_bus_front #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              chan_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  input  logic [1:0]        gp_lvl,
  input  logic [1:0]        baud_clk,
  input  logic [1:0]        rx_rdy,
  output logic [1:0]        mf_out
);
  import dcbf_pkg::*;

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] we_vec;
  logic              wr_evt;
  logic              bcast;
  logic              rd_act;
  logic [DATA_W-1:0] rdata [NUM_CH];
  logic [DATA_W-1:0] cfg   [NUM_CH];
  logic [NUM_CH-1:0] bcast_bits;

  bus_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel), .wr_n(wr_n),
    .bcast(bcast), .wr_evt(wr_evt), .we_vec(we_vec)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chan_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst(rst), .we(we_vec[ch]), .waddr(addr), .wdata(wr_data),
      .raddr(addr), .rdata(rdata[ch]), .cfg(cfg[ch])
    );
    assign bcast_bits[ch] = cfg[ch][0];
    mf_select u_mf (
      .clk(clk), .rst(rst), .sel(cfg[ch][2:1]), .gp(gp_lvl[ch]),
      .baud(baud_clk[ch]), .rx(rx_rdy[ch]), .mf(mf_out[ch])
    );
  end

  assign bcast   = |bcast_bits;
  assign rd_act  = ~cs_n & ~rd_n;
  assign rd_oe   = rd_act;
  assign rd_data = rd_act ? rdata[chan_index(chan_sel)] : '0;

  a_r8_idle_bus: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> (rd_data == '0 && !rd_oe));
  a_r1_cleared: assert property (@(posedge clk)
    $past(rst) |-> (!bcast && mf_out == 2'b00 || gp_lvl != 2'b00));

endmodule

// File: tb/dual_chan_bus_front_test.sv
module dual_chan_bus_front_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, chan_sel = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_oe;
  logic [1:0] gp_lvl = '0, baud_clk = '0, rx_rdy = '0;
  logic [1:0] mf_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [2][8];   // [0]=A, [1]=B

  always #2 clk = ~clk;

  dual_chan_bus_front uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel), .addr(addr),
    .wr_n(wr_n), .rd_n(rd_n), .wr_data(wr_data), .rd_data(rd_data),
    .rd_oe(rd_oe), .gp_lvl(gp_lvl), .baud_clk(baud_clk), .rx_rdy(rx_rdy),
    .mf_out(mf_out)
  );

  typedef struct packed {
    logic       ch;   // 1 = A
    logic [2:0] a;
    logic [7:0] d;
  } wvec_t;

  localparam wvec_t WTAB [10] = '{
    '{1'b1, 3'd0, 8'h11}, '{1'b0, 3'd0, 8'hE1}, '{1'b1, 3'd1, 8'h22},
    '{1'b0, 3'd1, 8'hD2}, '{1'b1, 3'd3, 8'h33}, '{1'b0, 3'd6, 8'hC6},
    '{1'b1, 3'd7, 8'h04}, '{1'b0, 3'd7, 8'h02}, '{1'b1, 3'd5, 8'h55},
    '{1'b0, 3'd2, 8'hB2}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_bcast();
    return ref_mem[0][7][0] | ref_mem[1][7][0];
  endfunction

  task automatic ref_clear();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) ref_mem[c][a] = '0;
  endtask

  task automatic bus_write(input logic cs, input logic ch, input logic [2:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    cs_n = cs; chan_sel = ch; addr = a; wr_data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    if (!cs) begin
      if (ref_bcast()) begin
        ref_mem[0][a] = d; ref_mem[1][a] = d;
      end else begin
        ref_mem[ch ? 0 : 1][a] = d;
      end
    end
  endtask

  task automatic bus_read(input logic ch, input logic [2:0] a,
                          input logic [7:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; chan_sel = ch; addr = a; rd_n = 1'b0;
    #1;
    check(req, {23'd0, rd_oe, rd_data}, {23'd0, 1'b1, exp});
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++)
        bus_read(c == 0, 3'(a), ref_mem[c][a], req);
  endtask

  function automatic logic exp_mf(input logic [1:0] s, input logic g,
                                  input logic b, input logic r);
    logic [3:0] choices;
    choices = {1'b0, r, b, g};
    return choices[s];
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 idle bus, R1 reset contents
    @(negedge clk); #1;
    check("R8 idle", {rd_oe, rd_data}, 9'd0);
    check("R1 mf after reset", {30'd0, mf_out}, 32'd0);
    read_all("R1 reset clear");

    // R3/R4: vector table of writes, then full readback
    foreach (WTAB[i]) bus_write(1'b0, WTAB[i].ch, WTAB[i].a, WTAB[i].d);
    read_all("R3 R4 table readback");

    // R2: write with cs_n high ignored; read with cs_n high idle
    bus_write(1'b1, 1'b1, 3'd0, 8'hFF);
    bus_read(1'b1, 3'd0, ref_mem[0][0], "R2 write ignored");
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R2 read without cs", {rd_oe, rd_data}, 9'd0);
    rd_n = 1'b1;

    // R5: hold wr_n low, change address, commit at rise
    @(negedge clk);
    cs_n = 1'b0; chan_sel = 1'b1; addr = 3'd2; wr_data = 8'hAA; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = 3'd4; wr_data = 8'h5C; rd_n = 1'b0; #1;
    check("R5 no commit while low", rd_data, ref_mem[0][4]);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    ref_mem[0][4] = 8'h5C;
    bus_read(1'b1, 3'd4, 8'h5C, "R5 commit on rise");
    bus_read(1'b1, 3'd2, ref_mem[0][2], "R5 early address unused");

    // R6: broadcast on via channel A config bit 0
    bus_write(1'b0, 1'b1, 3'd7, 8'h01);
    bus_write(1'b0, 1'b0, 3'd6, 8'h77);
    bus_read(1'b1, 3'd6, 8'h77, "R6 broadcast to A");
    bus_read(1'b0, 3'd6, 8'h77, "R6 broadcast to B");
    // R7: reads still follow chan_sel
    bus_read(1'b1, 3'd1, 8'h22, "R7 read A in broadcast");
    bus_read(1'b0, 3'd1, 8'hD2, "R7 read B in broadcast");
    // broadcast write of config clears bit 0 in both channels
    bus_write(1'b0, 1'b1, 3'd7, 8'h00);
    bus_write(1'b0, 1'b0, 3'd3, 8'h99);
    read_all("R6 broadcast off again");

    // R9: all select codes, channel B set to the complementary code
    gp_lvl = 2'b01; baud_clk = 2'b10; rx_rdy = 2'b11;
    for (int s = 0; s < 4; s++) begin
      bus_write(1'b0, 1'b1, 3'd7, {5'd0, 2'(s), 1'b0});
      bus_write(1'b0, 1'b0, 3'd7, {5'd0, 2'(3 - s), 1'b0});
      #1;
      check("R9 mf A", {31'd0, mf_out[0]},
            {31'd0, exp_mf(2'(s), gp_lvl[0], baud_clk[0], rx_rdy[0])});
      check("R9 mf B", {31'd0, mf_out[1]},
            {31'd0, exp_mf(2'(3 - s), gp_lvl[1], baud_clk[1], rx_rdy[1])});
      gp_lvl = ~gp_lvl; baud_clk = ~baud_clk; rx_rdy = ~rx_rdy; #1;
      check("R9 mf A follows", {31'd0, mf_out[0]},
            {31'd0, exp_mf(2'(s), gp_lvl[0], baud_clk[0], rx_rdy[0])});
    end

    // R1: reset mid-run clears registers and broadcast
    bus_write(1'b0, 1'b1, 3'd7, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ref_clear();
    bus_write(1'b0, 1'b0, 3'd0, 8'h3C);
    read_all("R1 reset mid-run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule